// File: doc/BRIEF.md
# Associative Memory Pattern Matcher

This block is a small content-addressable bank of track patterns. Each stored pattern keeps one reference word per detector layer. Every word has its own comparator, and each comparator watches the hit bus of its layer on every cycle. When a hit on that bus equals the stored word, a sticky flag is set for that layer of that pattern. Hits can come in any order and with any gap between them, so over an event each pattern fills in like a scorecard.

A pattern fires once the number of its set layer flags reaches a threshold chosen by the user. When the end-of-event input is pulsed, hit intake stops and the fired patterns are captured. Patterns whose kill bit is set at that moment are left out. The captured patterns are then drained over a valid/ready road bus, lowest address first, one per accepted transfer. Each road carries a per-layer hit bitmap and four sub-strip occupancy bits per layer, taken from the two lowest bits of the matching hits. After the last road is accepted, every flag is cleared in one cycle and the bank is ready for the next event.

Reference words are loaded through a write port that takes a pattern address, a layer and a word. The port only takes effect while the bank is idle.

Top module: `am_pattern_matcher`

## Requirements
- R1: After reset, `road_valid` is 0 and `bank_idle` is 1.
- R2: A hit on layer l matches pattern p only if hit bits [17:2] equal the word stored for pattern p, layer l. Hit bits [1:0] are not part of the comparison. Words stored for other layers are never compared with that bus.
- R3: A layer flag, once set, stays set until the end-of-event clear. Hits may therefore arrive in any order and any number of cycles apart.
- R4: A pattern fires when the count of its set layer flags is at least `fire_threshold`. With a threshold of 5, one missing layer is tolerated.
- R5: A pattern whose `kill` bit is 1 in the cycle `end_of_event` is sampled is not reported.
- R6: Fired patterns are reported in increasing address order, one per cycle in which `road_valid` and `road_ready` are both 1. While `road_ready` is 0, the road on offer stays unchanged.
- R7: Bit l of `road_bitmap` is 1 exactly when layer l of the reported pattern was matched during the event.
- R8: Bit 4*l+k of `road_sub` is 1 when some matching hit on layer l had bits [1:0] equal to k.
- R9: Hits presented in the `end_of_event` cycle, or while roads are being drained, are ignored. After the last road is accepted, all flags and sub-strip bits are cleared, so the next event starts empty.
- R10: A write sets word `wr_word` for layer `wr_layer` of pattern `wr_addr`, but only when `bank_idle` is 1. At any other time the write is ignored.
- R11: If nothing fired, `bank_idle` is 0 in the cycle after `end_of_event` and returns to 1 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 6 | One valid bit per layer bus |
| hit_data | input | 108 | Six 18-bit hit words; layer l occupies bits [18l+17:18l] |
| end_of_event | input | 1 | One-cycle pulse that closes the event |
| fire_threshold | input | 3 | Minimum number of matched layers for a pattern to fire |
| kill | input | 16 | Per-pattern suppression, sampled together with end_of_event |
| wr_en | input | 1 | Write strobe for a reference word |
| wr_addr | input | 4 | Pattern address to write |
| wr_layer | input | 3 | Layer to write |
| wr_word | input | 16 | Reference word, compared against hit bits [17:2] |
| bank_idle | output | 1 | Collecting with no flag set; writes are taken |
| road_valid | output | 1 | A road is on offer |
| road_ready | input | 1 | Consumer accepts the road on offer |
| road_addr | output | 4 | Address of the fired pattern |
| road_bitmap | output | 6 | Matched-layer bitmap of that pattern |
| road_sub | output | 24 | Four sub-strip bits per layer |

## Verification
The assertions assume that `fire_threshold` is held steady through an event and its drain, because the road checks compare the reported bitmap against the current threshold. They also assume that `end_of_event` arrives as a single pulse from the collecting state. The stimulus changes the threshold only while the bank is idle. It pulses `end_of_event` for exactly one cycle and then waits for the bank to return to idle before it starts the next scenario. All inputs are driven one time unit after the rising edge, and every writeback happens while the bank is idle, apart from the single write that is meant to be dropped.

// File: rtl/am_pkg.sv
package am_pkg;
    // Hit bits below this position select a sub-strip and are not compared
    localparam int SUB_LSB = 2;
    localparam int SUB_N   = 1 << SUB_LSB;

    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_DRAIN   = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/am_lowest_first.sv
module am_lowest_first #(
    parameter int N  = 16,
    parameter int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);
    // Scan from the top down so the lowest set request wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end
endmodule

// File: rtl/am_pattern_row.sv
module am_pattern_row
    import am_pkg::*;
#(
    parameter int L      = 6,
    parameter int HIT_W  = 18,
    parameter int CNT_W  = 3,
    localparam int LW    = (L > 1) ? $clog2(L) : 1,
    localparam int CMP_W = HIT_W - SUB_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [L-1:0]         hit_valid,
    input  logic [L*HIT_W-1:0]   hit_data,
    input  logic                 accept,
    input  logic                 clear,
    input  logic                 wr_sel,
    input  logic [LW-1:0]        wr_layer,
    input  logic [CMP_W-1:0]     wr_word,
    input  logic [CNT_W-1:0]     threshold,
    input  logic                 kill,
    output logic [L-1:0]         layer_flags,
    output logic [L*SUB_N-1:0]   sub_bits,
    output logic                 fired
);
    typedef struct packed {
        logic [L-1:0][CMP_W-1:0] word;
        logic [L-1:0]            flag;
        logic [L-1:0][SUB_N-1:0] sub;
    } row_t;

    row_t row_d, row_q;
    logic [CNT_W-1:0] flag_cnt;

    always_comb begin
        logic [HIT_W-1:0]   hit;
        logic [SUB_LSB-1:0] lsb;
        row_d = row_q;
        for (int l = 0; l < L; l++) begin
            hit = hit_data[l*HIT_W +: HIT_W];
            lsb = hit[SUB_LSB-1:0];
            if (accept && hit_valid[l] && (hit[HIT_W-1:SUB_LSB] == row_q.word[l])) begin
                row_d.flag[l]     = 1'b1;
                row_d.sub[l][lsb] = 1'b1;
            end
            if (wr_sel && (wr_layer == LW'(l))) begin
                row_d.word[l] = wr_word;
            end
        end
        if (clear) begin
            row_d.flag = '0;
            row_d.sub  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    always_comb begin
        flag_cnt = '0;
        for (int l = 0; l < L; l++) flag_cnt = flag_cnt + CNT_W'(row_q.flag[l]);
    end

    assign fired       = (flag_cnt >= threshold) && !kill;
    assign layer_flags = row_q.flag;
    assign sub_bits    = row_q.sub;

    // R3: set flags are never lost except by the event clear
    assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((row_q.flag & $past(row_q.flag)) == $past(row_q.flag)));

    // R9: the clear empties flags and sub-strip bits
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (row_q.flag == '0) && (row_q.sub == '0));

    // R10: stored words change only on a selected write
    assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(row_q.word));
endmodule

// File: rtl/am_pattern_matcher.sv
module am_pattern_matcher
    import am_pkg::*;
#(
    parameter int NUM_LAYERS   = 6,
    parameter int HIT_W        = 18,
    parameter int NUM_PATTERNS = 16,
    localparam int AW    = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1,
    localparam int LW    = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int CNT_W = $clog2(NUM_LAYERS + 1),
    localparam int CMP_W = HIT_W - SUB_LSB
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LAYERS-1:0]         hit_valid,
    input  logic [NUM_LAYERS*HIT_W-1:0]   hit_data,
    input  logic                          end_of_event,
    input  logic [CNT_W-1:0]              fire_threshold,
    input  logic [NUM_PATTERNS-1:0]       kill,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [LW-1:0]                 wr_layer,
    input  logic [CMP_W-1:0]              wr_word,
    output logic                          bank_idle,
    output logic                          road_valid,
    input  logic                          road_ready,
    output logic [AW-1:0]                 road_addr,
    output logic [NUM_LAYERS-1:0]         road_bitmap,
    output logic [NUM_LAYERS*SUB_N-1:0]   road_sub
);
    typedef struct packed {
        ctl_state_e              state;
        logic [NUM_PATTERNS-1:0] pending;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                          accept;
    logic                          clear;
    logic [NUM_PATTERNS-1:0]       fired_vec;
    logic [NUM_PATTERNS-1:0]       row_busy;
    logic [NUM_PATTERNS-1:0]       wr_sel;
    logic [NUM_LAYERS-1:0]         flags_arr [NUM_PATTERNS];
    logic [NUM_LAYERS*SUB_N-1:0]   sub_arr   [NUM_PATTERNS];
    logic                          enc_found;
    logic [AW-1:0]                 enc_idx;

    genvar p;
    generate
        for (p = 0; p < NUM_PATTERNS; p++) begin : g_row
            assign wr_sel[p]   = wr_en && bank_idle && (wr_addr == AW'(p));
            assign row_busy[p] = |flags_arr[p];
            am_pattern_row #(
                .L     (NUM_LAYERS),
                .HIT_W (HIT_W),
                .CNT_W (CNT_W)
            ) u_row (
                .clk         (clk),
                .rst_n       (rst_n),
                .hit_valid   (hit_valid),
                .hit_data    (hit_data),
                .accept      (accept),
                .clear       (clear),
                .wr_sel      (wr_sel[p]),
                .wr_layer    (wr_layer),
                .wr_word     (wr_word),
                .threshold   (fire_threshold),
                .kill        (kill[p]),
                .layer_flags (flags_arr[p]),
                .sub_bits    (sub_arr[p]),
                .fired       (fired_vec[p])
            );
        end
    endgenerate

    am_lowest_first #(
        .N  (NUM_PATTERNS),
        .AW (AW)
    ) u_enc (
        .req   (ctl_q.pending),
        .found (enc_found),
        .idx   (enc_idx)
    );

    always_comb begin
        ctl_d  = ctl_q;
        accept = 1'b0;
        clear  = 1'b0;
        case (ctl_q.state)
            ST_COLLECT: begin
                if (end_of_event) begin
                    ctl_d.state   = ST_DRAIN;
                    ctl_d.pending = fired_vec;
                end else begin
                    accept = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!enc_found) begin
                    clear       = 1'b1;
                    ctl_d.state = ST_COLLECT;
                end else if (road_ready) begin
                    ctl_d.pending[enc_idx] = 1'b0;
                end
            end
            default: ctl_d.state = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_COLLECT, pending: '0};
        else        ctl_q <= ctl_d;
    end

    assign bank_idle   = (ctl_q.state == ST_COLLECT) && !(|row_busy);
    assign road_valid  = (ctl_q.state == ST_DRAIN) && enc_found;
    assign road_addr   = enc_idx;
    assign road_bitmap = flags_arr[enc_idx];
    assign road_sub    = sub_arr[enc_idx];

    // R6: an unaccepted road is held unchanged
    assert_road_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && !road_ready) |=> road_valid && $stable(road_addr)
            && $stable(road_bitmap) && $stable(road_sub));

    // R6: after a transfer the next road has a higher address
    assert_road_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && road_ready) |=> (!road_valid || (road_addr > $past(road_addr))));

    // R4: every reported road meets the threshold
    assert_road_threshold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        road_valid |-> ($countones(road_bitmap) >= int'(fire_threshold)));

    // R9: roads appear only outside the idle state
    assert_road_not_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        road_valid |-> !bank_idle);
endmodule

// File: tb/tb_am_pattern_matcher.sv
module tb_am_pattern_matcher;
    localparam int L = 6;
    localparam int HW = 18;
    localparam int NP = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [L-1:0]   hit_valid = '0;
    logic [L*HW-1:0] hit_data = '0;
    logic           end_of_event = 1'b0;
    logic [2:0]     fire_threshold = 3'd6;
    logic [NP-1:0]  kill = '0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [2:0]     wr_layer = '0;
    logic [15:0]    wr_word = '0;
    logic           bank_idle;
    logic           road_valid;
    logic           road_ready = 1'b0;
    logic [3:0]     road_addr;
    logic [L-1:0]   road_bitmap;
    logic [L*4-1:0] road_sub;

    int n_checks = 0;
    int n_fail   = 0;
    int n_got;
    int got_addr [8];
    int got_map  [8];
    int got_sub  [8];

    always #2 clk = ~clk;

    am_pattern_matcher dut (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_data(hit_data),
        .end_of_event(end_of_event), .fire_threshold(fire_threshold), .kill(kill),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_layer(wr_layer), .wr_word(wr_word),
        .bank_idle(bank_idle), .road_valid(road_valid), .road_ready(road_ready),
        .road_addr(road_addr), .road_bitmap(road_bitmap), .road_sub(road_sub)
    );

    function automatic logic [15:0] word_of(int p, int l);
        return 16'(p * 16 + l + 1);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // present hits for pattern p on the layers in mask, one cycle
    task automatic send_hits(logic [L-1:0] mask, int p, logic [1:0] lsb);
        for (int l = 0; l < L; l++) begin
            if (mask[l]) begin
                hit_valid[l] = 1'b1;
                hit_data[l*HW +: HW] = {word_of(p, l), lsb};
            end
        end
        tick();
        hit_valid = '0;
    endtask

    // pulse end of event and gather all roads with ready held high
    task automatic close_event(logic [NP-1:0] kv);
        end_of_event = 1'b1;
        kill = kv;
        road_ready = 1'b1;
        tick();
        end_of_event = 1'b0;
        kill = '0;
        n_got = 0;
        for (int i = 0; i < 60; i++) begin
            if (road_valid) begin
                if (n_got < 8) begin
                    got_addr[n_got] = int'(road_addr);
                    got_map[n_got]  = int'(road_bitmap);
                    got_sub[n_got]  = int'(road_sub);
                end
                n_got++;
            end else if (bank_idle) begin
                break;
            end
            tick();
        end
        road_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(road_valid == 1'b0, "R1", "road_valid after reset", int'(road_valid), 0);
        chk(bank_idle == 1'b1, "R1", "bank_idle after reset", int'(bank_idle), 1);
    endtask

    task automatic t_load();
        for (int p = 0; p < NP; p++) begin
            for (int l = 0; l < L; l++) begin
                wr_en = 1'b1; wr_addr = 4'(p); wr_layer = 3'(l); wr_word = word_of(p, l);
                tick();
            end
        end
        wr_en = 1'b0;
    endtask

    task automatic t_any_order();
        int exp_sub;
        fire_threshold = 3'd6;
        exp_sub = 0;
        for (int l = L - 1; l >= 0; l--) begin
            send_hits(6'(1 << l), 3, 2'(l % 4));
            exp_sub |= 1 << (l * 4 + (l % 4));
            tick(); tick(); tick();
        end
        send_hits(6'b000001, 3, 2'd3);
        exp_sub |= 1 << 3;
        close_event('0);
        chk(n_got == 1, "R3", "road count", n_got, 1);
        chk(got_addr[0] == 3, "R3", "road address", got_addr[0], 3);
        chk(got_map[0] == 'h3F, "R7", "bitmap", got_map[0], 'h3F);
        chk(got_sub[0] == exp_sub, "R8", "sub-strip bits", got_sub[0], exp_sub);
    endtask

    task automatic t_compare_rules();
        fire_threshold = 3'd6;
        send_hits(6'b111110, 5, 2'd2);
        // layer 0 word of pattern 5 placed on layer 1 bus
        hit_valid[1] = 1'b1;
        hit_data[1*HW +: HW] = {word_of(5, 0), 2'd1};
        tick();
        hit_valid = '0;
        close_event('0);
        chk(n_got == 0, "R2", "wrong-layer word fired", n_got, 0);
        // next event: only the missing layer; earlier flags must be gone
        send_hits(6'b000001, 5, 2'd0);
        close_event('0);
        chk(n_got == 0, "R9", "flags survived clear", n_got, 0);
        // LSBs differ from stored zeros yet still match
        send_hits(6'b111111, 5, 2'd3);
        close_event('0);
        chk(n_got == 1 && got_addr[0] == 5, "R2", "lsb-insensitive match", got_addr[0], 5);
    endtask

    task automatic t_order();
        fire_threshold = 3'd6;
        send_hits(6'b111111, 9, 2'd0);
        send_hits(6'b111111, 2, 2'd0);
        send_hits(6'b111111, 5, 2'd0);
        close_event('0);
        chk(n_got == 3, "R6", "road count", n_got, 3);
        chk(got_addr[0] == 2, "R6", "first road", got_addr[0], 2);
        chk(got_addr[1] == 5, "R6", "second road", got_addr[1], 5);
        chk(got_addr[2] == 9, "R6", "third road", got_addr[2], 9);
    endtask

    task automatic t_threshold();
        fire_threshold = 3'd5;
        send_hits(6'b111011, 7, 2'd1);
        send_hits(6'b001111, 8, 2'd1);
        close_event('0);
        chk(n_got == 1, "R4", "road count at threshold 5", n_got, 1);
        chk(got_addr[0] == 7, "R4", "address", got_addr[0], 7);
        chk(got_map[0] == 'h3B, "R7", "bitmap with gap", got_map[0], 'h3B);
        fire_threshold = 3'd6;
    endtask

    task automatic t_kill();
        send_hits(6'b111111, 4, 2'd0);
        send_hits(6'b111111, 6, 2'd0);
        close_event(16'h0010);
        chk(n_got == 1, "R5", "road count with kill", n_got, 1);
        chk(got_addr[0] == 6, "R5", "surviving road", got_addr[0], 6);
    endtask

    task automatic t_backpressure();
        send_hits(6'b111111, 11, 2'd0);
        send_hits(6'b111111, 1, 2'd0);
        end_of_event = 1'b1;
        road_ready = 1'b0;
        tick();
        end_of_event = 1'b0;
        chk(road_valid && road_addr == 4'd1, "R6", "first offer", int'(road_addr), 1);
        tick(); tick(); tick(); tick();
        chk(road_valid && road_addr == 4'd1, "R6", "held offer", int'(road_addr), 1);
        road_ready = 1'b1;
        tick();
        chk(road_valid && road_addr == 4'd11, "R6", "next offer", int'(road_addr), 11);
        tick();
        chk(!road_valid, "R6", "drained", int'(road_valid), 0);
        road_ready = 1'b0;
        tick();
        chk(bank_idle, "R9", "idle after drain", int'(bank_idle), 1);
    endtask

    task automatic t_eoe_cycle_hit();
        send_hits(6'b011111, 12, 2'd0);
        hit_valid[5] = 1'b1;
        hit_data[5*HW +: HW] = {word_of(12, 5), 2'd0};
        end_of_event = 1'b1;
        road_ready = 1'b1;
        tick();
        hit_valid = '0;
        end_of_event = 1'b0;
        n_got = 0;
        for (int i = 0; i < 10; i++) begin
            if (road_valid) n_got++;
            else if (bank_idle) break;
            tick();
        end
        road_ready = 1'b0;
        chk(n_got == 0, "R9", "hit in end-of-event cycle taken", n_got, 0);
    endtask

    task automatic t_write_busy();
        send_hits(6'b000001, 0, 2'd0);
        chk(!bank_idle, "R10", "busy after hit", int'(bank_idle), 0);
        wr_en = 1'b1; wr_addr = 4'd0; wr_layer = 3'd3; wr_word = 16'hABC;
        tick();
        wr_en = 1'b0;
        close_event('0);
        chk(n_got == 0, "R10", "partial event roads", n_got, 0);
        send_hits(6'b111111, 0, 2'd0);
        close_event('0);
        chk(n_got == 1 && got_addr[0] == 0, "R10", "original word kept", n_got, 1);
    endtask

    task automatic t_empty_event();
        end_of_event = 1'b1;
        tick();
        end_of_event = 1'b0;
        chk(!bank_idle && !road_valid, "R11", "draining cycle", int'(bank_idle), 0);
        tick();
        chk(bank_idle, "R11", "idle again", int'(bank_idle), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_load();
        t_any_order();
        t_compare_rules();
        t_order();
        t_threshold();
        t_kill();
        t_backpressure();
        t_eoe_cycle_hit();
        t_write_busy();
        t_empty_event();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule